// File: doc/BRIEF.md
# CAN Message Acceptance Filter Bank

This block decides which of a bank of message centers takes a received CAN frame. When a frame completes, the receiver presents the frame's fields for one cycle: the identifier, the extended-format flag, the remote flag, the data length and the first two data bytes. Every center holds an acceptance identifier and a few control bits. Each center tests the frame in parallel. A priority picker then reports the winning center one cycle later.

Centers 1 to NUM_CTR-1 act as ordinary centers. Each is set to receive or to transmit. A transmit center answers only a remote frame that carries its identifier, and only when all of its readiness bits allow a send. The winner is then flagged as a transmit request. The last center can only receive. It is a catch-all that takes only frames no other center took, and it compares the identifier under its own mask instead of the global ones.

Top module: `acf_bank`

## Requirements
- R1: During and right after reset, `hit_vld`, `tx_req` and `hit_idx` are all 0.
- R2: The result of a frame presented with `frm_vld`=1 appears on the next rising clock edge and lasts one cycle. When `hit_vld`=0, `hit_idx` and `tx_req` are 0, and without `frm_vld` no result appears.
- R3: In masked mode, an extended frame compares all EXT_W identifier bits under `ext_mask`. A standard frame compares only the low STD_W bits under `std_mask`. A mask bit of 1 means the bit is compared.
- R4: A center with `ctr_mask_en`=0 compares every identifier bit of the frame's format, whatever the global masks hold.
- R5: A center matches only when its `ctr_ext` bit equals `frm_ext`.
- R6: For a data frame with `frm_dlc` >= 2, `frm_media` must equal `media_val` in every bit where `media_mask` is 1.
- R7: The media comparison is skipped for remote frames (`frm_rtr`=1) and for frames with `frm_dlc` < 2.
- R8: When several ordinary centers accept a frame, the lowest-numbered one wins. `hit_idx` reports the center number counted from 1.
- R9: The last center (number NUM_CTR) accepts a frame only when no ordinary center does. It uses `last_mask` in place of the global identifier masks, and its direction bit is ignored.
- R10: A center with `ctr_tx`=1 accepts only remote frames. It needs `ctr_rdy`=1, `ctr_inhibit`=0, `ctr_fresh`=1 and `ctr_armed`=1. When it wins, `tx_req`=1. Any other winner gives `tx_req`=0.
- R11: A receive center with `ctr_rdy`=0 accepts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | Frame fields valid, one cycle |
| frm_id | input | EXT_W | Frame identifier; standard frames use the low STD_W bits |
| frm_ext | input | 1 | 1 = extended identifier format |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_dlc | input | 4 | Data length code |
| frm_media | input | MEDIA_W | First two data bytes |
| ctr_id | input | NUM_CTR*EXT_W | Acceptance identifiers; center k sits at slice k-1 |
| ctr_tx | input | NUM_CTR | 1 = transmit center (bit of the last center ignored) |
| ctr_ext | input | NUM_CTR | Center expects extended format |
| ctr_mask_en | input | NUM_CTR | 1 = masked identifier test |
| ctr_rdy | input | NUM_CTR | Center ready |
| ctr_inhibit | input | NUM_CTR | Transmit inhibited |
| ctr_fresh | input | NUM_CTR | Transmit data updated |
| ctr_armed | input | NUM_CTR | Transmit request armed |
| std_mask | input | STD_W | Global standard identifier mask |
| ext_mask | input | EXT_W | Global extended identifier mask |
| last_mask | input | EXT_W | Identifier mask of the last center |
| media_val | input | MEDIA_W | Expected media bytes |
| media_mask | input | MEDIA_W | Media compare mask |
| hit_vld | output | 1 | Accept strobe |
| hit_idx | output | IDX_W | Winning center number, 1-based |
| tx_req | output | 1 | Winner is a transmit center answering a remote frame |

## Verification
The bench builds the block with NUM_CTR=6, STD_W=11, EXT_W=29 and MEDIA_W=16. Six centers keep the catch-all one step away from the ordinary centers, so frames that miss every ordinary center reach it often. Overlapping identifiers among five ordinary centers test the priority order. The full identifier widths keep the standard and extended masks fully apart. Random frames use identifiers drawn from a small set, so that hits, ties and misses all happen often.

// File: rtl/acf_pkg.sv
package acf_pkg;
   localparam int DLC_W = 4;

   // Media bytes take part only in data frames that carry both bytes.
   function automatic logic media_needed(input logic rtr, input logic [DLC_W-1:0] dlc);
      return !rtr && (dlc >= DLC_W'(2));
   endfunction
endpackage

// File: rtl/acf_center.sv
module acf_center #(
   parameter int EXT_W = 29,
   parameter int STD_W = 11
) (
   input  logic [EXT_W-1:0] f_id,
   input  logic             f_ext,
   input  logic             f_rtr,
   input  logic             media_ok,
   input  logic [EXT_W-1:0] sel_mask,
   input  logic [EXT_W-1:0] acc_id,
   input  logic             dir_tx,
   input  logic             ext_mode,
   input  logic             mask_en,
   input  logic             ready,
   input  logic             inhibit,
   input  logic             fresh,
   input  logic             armed,
   output logic             hit
);
   localparam logic [EXT_W-1:0] STD_FULL = EXT_W'((64'd1 << STD_W) - 64'd1);

   logic [EXT_W-1:0] cmp_mask;
   logic             id_ok, fmt_ok, rx_take, tx_fire;

   always_comb begin
      if (mask_en) cmp_mask = sel_mask;
      else         cmp_mask = f_ext ? '1 : STD_FULL;
   end

   assign id_ok   = ((f_id ^ acc_id) & cmp_mask) == '0;
   assign fmt_ok  = (ext_mode == f_ext);
   assign rx_take = !dir_tx && ready && media_ok;
   assign tx_fire = dir_tx && f_rtr && ready && !inhibit && fresh && armed;
   assign hit     = id_ok && fmt_ok && (rx_take || tx_fire);
endmodule

// File: rtl/acf_pick.sv
module acf_pick #(
   parameter int N     = 5,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i + 1);
      end
   end

   assign grant = req & ~(req - N'(1));
   assign any   = |req;
endmodule

// File: rtl/acf_bank.sv
module acf_bank #(
   parameter int NUM_CTR = 15,
   parameter int STD_W   = 11,
   parameter int EXT_W   = 29,
   parameter int MEDIA_W = 16,
   parameter int IDX_W   = $clog2(NUM_CTR + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frm_vld,
   input  logic [EXT_W-1:0]         frm_id,
   input  logic                     frm_ext,
   input  logic                     frm_rtr,
   input  logic [3:0]               frm_dlc,
   input  logic [MEDIA_W-1:0]       frm_media,
   input  logic [NUM_CTR*EXT_W-1:0] ctr_id,
   input  logic [NUM_CTR-1:0]       ctr_tx,
   input  logic [NUM_CTR-1:0]       ctr_ext,
   input  logic [NUM_CTR-1:0]       ctr_mask_en,
   input  logic [NUM_CTR-1:0]       ctr_rdy,
   input  logic [NUM_CTR-1:0]       ctr_inhibit,
   input  logic [NUM_CTR-1:0]       ctr_fresh,
   input  logic [NUM_CTR-1:0]       ctr_armed,
   input  logic [STD_W-1:0]         std_mask,
   input  logic [EXT_W-1:0]         ext_mask,
   input  logic [EXT_W-1:0]         last_mask,
   input  logic [MEDIA_W-1:0]       media_val,
   input  logic [MEDIA_W-1:0]       media_mask,
   output logic                     hit_vld,
   output logic [IDX_W-1:0]         hit_idx,
   output logic                     tx_req
);
   import acf_pkg::*;

   localparam int REG_N = NUM_CTR - 1;
   localparam logic [NUM_CTR-1:0] RX_ONLY_LAST = ~(NUM_CTR'(1) << (NUM_CTR - 1));
   localparam logic [EXT_W-1:0]   STD_FULL = EXT_W'((64'd1 << STD_W) - 64'd1);

   if (NUM_CTR < 2) begin : g_bad_n
      $error("acf_bank: NUM_CTR must be at least 2");
   end
   if (STD_W >= EXT_W) begin : g_bad_w
      $error("acf_bank: STD_W must be below EXT_W");
   end
   if (IDX_W < $clog2(NUM_CTR + 1)) begin : g_bad_idx
      $error("acf_bank: IDX_W too narrow for NUM_CTR");
   end

   logic [NUM_CTR-1:0] tx_eff, hit_raw;
   logic [EXT_W-1:0]   glob_mask, own_mask;
   logic               media_ok;
   logic [REG_N-1:0]   grant;
   logic [IDX_W-1:0]   pick_idx;
   logic               any_reg, any_hit, win_tx;

   assign tx_eff    = ctr_tx & RX_ONLY_LAST;
   assign media_ok  = !media_needed(frm_rtr, frm_dlc)
                      || (((frm_media ^ media_val) & media_mask) == '0);
   assign glob_mask = frm_ext ? ext_mask : {{(EXT_W-STD_W){1'b0}}, std_mask};
   assign own_mask  = frm_ext ? last_mask : (last_mask & STD_FULL);

   for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
      logic [EXT_W-1:0] msk;
      if (c == NUM_CTR - 1) begin : g_catch
         assign msk = own_mask;
      end else begin : g_reg
         assign msk = glob_mask;
      end
      acf_center #(.EXT_W(EXT_W), .STD_W(STD_W)) u_ctr (
         .f_id     (frm_id),
         .f_ext    (frm_ext),
         .f_rtr    (frm_rtr),
         .media_ok (media_ok),
         .sel_mask (msk),
         .acc_id   (ctr_id[c*EXT_W +: EXT_W]),
         .dir_tx   (tx_eff[c]),
         .ext_mode (ctr_ext[c]),
         .mask_en  (ctr_mask_en[c]),
         .ready    (ctr_rdy[c]),
         .inhibit  (ctr_inhibit[c]),
         .fresh    (ctr_fresh[c]),
         .armed    (ctr_armed[c]),
         .hit      (hit_raw[c])
      );
   end

   acf_pick #(.N(REG_N), .IDX_W(IDX_W)) u_pick (
      .req   (hit_raw[REG_N-1:0]),
      .grant (grant),
      .idx   (pick_idx),
      .any   (any_reg)
   );

   assign any_hit = any_reg || hit_raw[NUM_CTR-1];
   assign win_tx  = |(grant & tx_eff[REG_N-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_vld <= 1'b0;
         hit_idx <= '0;
         tx_req  <= 1'b0;
      end else if (frm_vld && any_hit) begin
         hit_vld <= 1'b1;
         hit_idx <= any_reg ? pick_idx : IDX_W'(NUM_CTR);
         tx_req  <= any_reg && win_tx;
      end else begin
         hit_vld <= 1'b0;
         hit_idx <= '0;
         tx_req  <= 1'b0;
      end
   end

   // R2: a result only follows a presented frame
   a_r2_vld_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld |-> $past(frm_vld));
   // R2: idle outputs are zero
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_vld |-> (hit_idx == '0 && !tx_req));
   // R8: reported center number lies in range
   a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld |-> (hit_idx >= IDX_W'(1) && hit_idx <= IDX_W'(NUM_CTR)));
   // R8: picker grants at most one ordinary center
   a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R9: catch-all loses to any ordinary hit
   a_r9_catch_yields: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && any_reg) |=> (hit_idx != IDX_W'(NUM_CTR)));
   // R9: catch-all never raises a transmit request
   a_r9_catch_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vld && hit_idx == IDX_W'(NUM_CTR)) |-> !tx_req);
   // R10: transmit requests answer remote frames only
   a_r10_tx_remote: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (hit_vld && $past(frm_rtr)));
endmodule

// File: tb/sim_acf_bank.sv
`timescale 1ns/1ps
module sim_acf_bank;
   localparam int N  = 6;
   localparam int SW = 11;
   localparam int EW = 29;
   localparam int MW = 16;
   localparam int IW = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          frm_vld = 0, frm_ext = 0, frm_rtr = 0;
   logic [EW-1:0] frm_id = '0;
   logic [3:0]    frm_dlc = '0;
   logic [MW-1:0] frm_media = '0;
   logic [EW-1:0] cid [N];
   logic [N-1:0]  c_tx, c_ext, c_men, c_rdy, c_inh, c_fre, c_arm;
   logic [N*EW-1:0] ctr_id;
   logic [SW-1:0] std_mask;
   logic [EW-1:0] ext_mask, last_mask;
   logic [MW-1:0] media_val, media_mask;
   logic          hit_vld, tx_req;
   logic [IW-1:0] hit_idx;

   always_comb
      for (int k = 0; k < N; k++) ctr_id[k*EW +: EW] = cid[k];

   acf_bank #(.NUM_CTR(N), .STD_W(SW), .EXT_W(EW), .MEDIA_W(MW)) u0 (
      .clk, .rst_n, .frm_vld, .frm_id, .frm_ext, .frm_rtr, .frm_dlc, .frm_media,
      .ctr_id, .ctr_tx(c_tx), .ctr_ext(c_ext), .ctr_mask_en(c_men), .ctr_rdy(c_rdy),
      .ctr_inhibit(c_inh), .ctr_fresh(c_fre), .ctr_armed(c_arm),
      .std_mask, .ext_mask, .last_mask, .media_val, .media_mask,
      .hit_vld, .hit_idx, .tx_req);

   int    n_chk = 0, n_fail = 0;
   string tag = "R1";
   bit    live = 0, done = 0;
   bit    e_vld, e_tx;
   int    e_idx;

   function automatic bit id_hit(input logic [EW-1:0] a, input logic [EW-1:0] m);
      logic [EW-1:0] full;
      full = frm_ext ? {EW{1'b1}} : EW'((1 << SW) - 1);
      m = m & full;
      for (int b = 0; b < EW; b++)
         if (m[b] && a[b] !== frm_id[b]) return 0;
      return 1;
   endfunction

   // Behavioural reference: scan centers in order, first taker wins.
   always @(posedge clk) begin
      bit med;
      e_vld = 0; e_idx = 0; e_tx = 0;
      if (rst_n && frm_vld) begin
         med = frm_rtr || frm_dlc < 2 || (((frm_media ^ media_val) & media_mask) == 0);
         for (int k = 0; k < N - 1 && !e_vld; k++) begin
            logic [EW-1:0] m;
            bit ok;
            m = !c_men[k] ? {EW{1'b1}} : (frm_ext ? ext_mask : EW'(std_mask));
            ok = id_hit(cid[k], m) && c_ext[k] == frm_ext && c_rdy[k];
            if (c_tx[k]) ok = ok && frm_rtr && !c_inh[k] && c_fre[k] && c_arm[k];
            else         ok = ok && med;
            if (ok) begin e_vld = 1; e_idx = k + 1; e_tx = c_tx[k]; end
         end
         if (!e_vld && c_rdy[N-1] && c_ext[N-1] == frm_ext && med
             && id_hit(cid[N-1], c_men[N-1] ? last_mask : {EW{1'b1}})) begin
            e_vld = 1; e_idx = N;
         end
      end
   end

   always @(negedge clk) begin
      if (live && !done) begin
         n_chk++;
         if (hit_vld !== e_vld || hit_idx !== IW'(e_idx) || tx_req !== e_tx) begin
            n_fail++;
            $display("FAIL %s: vld/idx/tx = %0b/%0d/%0b expected %0b/%0d/%0b",
                     tag, hit_vld, hit_idx, tx_req, e_vld, e_idx, e_tx);
         end
      end
   end

   task automatic cfg_default();
      for (int k = 0; k < N; k++) cid[k] = EW'(32'h100 + 16 * k);
      c_tx = '0; c_ext = '0; c_men = '1; c_rdy = '1; c_rdy[N-1] = 1'b0;
      c_inh = '0; c_fre = '1; c_arm = '1;
      std_mask = '1; ext_mask = '1; last_mask = '1;
      media_val = 16'hA55A; media_mask = '0;
   endtask

   task automatic frame(input string t, input logic [EW-1:0] id, input bit ext,
                        input bit rtr, input int dlc, input logic [MW-1:0] med);
      tag = t;
      frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_dlc = 4'(dlc); frm_media = med;
      frm_vld = 1;
      @(negedge clk);
      frm_vld = 0;
      @(negedge clk);
   endtask

   initial begin
      cfg_default();
      repeat (3) @(negedge clk);
      n_chk++;
      if (hit_vld !== 0 || hit_idx !== 0 || tx_req !== 0) begin
         n_fail++;
         $display("FAIL R1: vld/idx/tx = %0b/%0d/%0b expected 0/0/0", hit_vld, hit_idx, tx_req);
      end
      rst_n = 1;
      @(negedge clk);
      live = 1;
      @(negedge clk);
      // R1 / R2: no frame, no strobe
      tag = "R2"; repeat (3) @(negedge clk);
      // R3: global standard mask ignores low nibble
      std_mask = 11'h7F0;
      frame("R3", EW'(32'h12F), 0, 0, 8, 16'h0);
      cid[2] = EW'(32'h120);
      frame("R3", EW'(32'h12F), 0, 0, 8, 16'h0);
      frame("R3", EW'(32'h13F), 0, 0, 8, 16'h0);
      // R4: unmasked mode compares every bit
      c_men[2] = 0;
      frame("R4", EW'(32'h12F), 0, 0, 8, 16'h0);
      frame("R4", EW'(32'h120), 0, 0, 8, 16'h0);
      cfg_default();
      // R5 / R3: extended frames, format flag must agree
      cid[1] = EW'(32'h1ABCDE00); c_ext[1] = 1; ext_mask = EW'(32'h1FFFFF00);
      frame("R5", EW'(32'h1ABCDE77), 1, 0, 8, 16'h0);
      frame("R5", EW'(32'h1ABCDE00), 0, 0, 8, 16'h0);
      frame("R3", EW'(32'h1ABCDF00), 1, 0, 8, 16'h0);
      cfg_default();
      // R6: media bytes under the media mask
      media_mask = 16'hFFFF;
      frame("R6", EW'(32'h110), 0, 0, 8, 16'hA55A);
      frame("R6", EW'(32'h110), 0, 0, 8, 16'hA55B);
      media_mask = 16'hFF00;
      frame("R6", EW'(32'h110), 0, 0, 2, 16'hA5FF);
      // R7: media test skipped for remote and short frames
      media_mask = 16'hFFFF;
      frame("R7", EW'(32'h110), 0, 1, 0, 16'h0000);
      frame("R7", EW'(32'h110), 0, 0, 1, 16'h0000);
      cfg_default();
      // R8: lowest number wins
      cid[3] = EW'(32'h110); cid[4] = EW'(32'h110);
      frame("R8", EW'(32'h110), 0, 0, 8, 16'h0);
      frame("R8", EW'(32'h140), 0, 0, 8, 16'h0);
      // R9: catch-all with own mask, only when alone
      c_rdy[N-1] = 1; last_mask = '0; c_tx[N-1] = 1;
      frame("R9", EW'(32'h3FF), 0, 0, 8, 16'h0);
      frame("R9", EW'(32'h110), 0, 0, 8, 16'h0);
      last_mask = EW'(32'h7FF); cid[N-1] = EW'(32'h3FF);
      frame("R9", EW'(32'h3FE), 0, 0, 8, 16'h0);
      frame("R9", EW'(32'h3FF), 0, 1, 0, 16'h0);
      cfg_default();
      // R10: transmit center answers remote frames when eligible
      c_tx[0] = 1; cid[0] = EW'(32'h055);
      frame("R10", EW'(32'h055), 0, 1, 0, 16'h0);
      frame("R10", EW'(32'h055), 0, 0, 8, 16'h0);
      c_inh[0] = 1;
      frame("R10", EW'(32'h055), 0, 1, 0, 16'h0);
      c_inh[0] = 0; c_arm[0] = 0;
      frame("R10", EW'(32'h055), 0, 1, 0, 16'h0);
      c_arm[0] = 1; c_fre[0] = 0;
      frame("R10", EW'(32'h055), 0, 1, 0, 16'h0);
      cfg_default();
      // R11: receive center not ready
      c_rdy[1] = 0;
      frame("R11", EW'(32'h110), 0, 0, 8, 16'h0);
      // R8 / R10: random mix over a small identifier set
      for (int r = 0; r < 400; r++) begin
         for (int k = 0; k < N; k++) cid[k] = EW'($urandom_range(0, 3) + 32'h200);
         c_tx = N'($urandom); c_ext = N'($urandom) & N'($urandom);
         c_men = N'($urandom); c_rdy = N'($urandom) | N'($urandom);
         c_inh = N'($urandom) & N'($urandom); c_fre = N'($urandom) | N'($urandom);
         c_arm = N'($urandom) | N'($urandom);
         std_mask = SW'($urandom) | 11'h7FC; ext_mask = EW'($urandom) | EW'(32'h1FFFFFFC);
         last_mask = EW'($urandom); media_mask = MW'($urandom) & MW'($urandom);
         frame("R8", EW'($urandom_range(0, 3) + 32'h200), $urandom_range(0, 3) == 0,
               $urandom_range(0, 2) == 0, $urandom_range(0, 8), MW'($urandom));
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule